// File: doc/BRIEF.md
# Configurable Interrupt Pin Qualifier

This block turns four active-low interrupt pins into single-cycle pending pulses, one per pin. A pin counts as requesting only after it has been seen idle (high) for a minimum number of clock samples and then active (low) for a minimum number. Both minimums depend on a timing-mode bit in a small configuration register. In the asynchronous setting each pin also passes through a two-flop synchronizer before it is qualified.

The same register assigns roles to the pins. Pin 0 can be marked as carrying inter-agent message requests instead of interrupts. Pin 2 can be marked as the request line of an external interrupt controller. Pin 3 can be taken away from input duty and used as an acknowledge output. In that case a latched acknowledge level is held until the bus logic reloads it. The pin is driven open-drain, which is modelled here as a pull-low enable. Each pending pulse on pin 0 or pin 2 carries a type flag that reflects the role the pin had when it qualified. Prioritisation and vectoring are left to the consumer of the pulses.

Top module: `pin_irq_qualifier`

## Requirements
- R1: With the mode bit (cfgData bit 0) clear, a pin that has been sampled high for at least one cycle and then goes low raises its `pend` bit in the second clock after the low level is presented.
- R2: With cfgData bit 0 set, a pin must be sampled high for at least two cycles and then low for at least two cycles. Its `pend` bit then rises in the fourth clock after the low level is presented.
- R3: In the asynchronous setting, a low pulse lasting one clock produces no pending pulse. A high gap of one clock between two low stretches does not re-arm the pin.
- R4: Each qualification gives a `pend` pulse exactly one cycle wide. A pin held low never fires again until it has returned high and qualified anew.
- R5: When cfgData bit 3 is set, every pin-0 pending pulse comes with `typeMsg` high in the same cycle. `typeMsg` is never high without a pin-0 pulse.
- R6: When cfgData bit 1 is set, every pin-2 pending pulse comes with `typeExt` high in the same cycle. `typeExt` is never high without a pin-2 pulse.
- R7: When cfgData bit 2 is set, pin 3 is ignored as an input, so `pend[3]` stays low. `ackDriveEn` then follows the latched acknowledge level one clock after `ackLoad`.
- R8: While `ackLoad` is low and no configuration write occurs, `ackDriveEn` holds its value.
- R9: During reset, `pend`, `typeMsg`, `typeExt` and `ackDriveEn` are all low, and the configuration returns to zero.
- R10: A configuration write that changes a pin's role bit, or the mode bit, discards that pin's idle history. The pin must be sampled high again before a low level qualifies. Pins whose role did not change keep qualifying in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration register write strobe |
| cfgData | input | 4 | Configuration value: bit0 async mode, bit1 pin 2 external-controller role, bit2 pin 3 acknowledge role, bit3 pin 0 message role |
| pinN | input | 4 | Active-low interrupt pins |
| ackLoad | input | 1 | Loads the acknowledge latch |
| ackAssert | input | 1 | Value loaded into the acknowledge latch (1 = pull pin low) |
| pend | output | 4 | One-cycle pending pulse per pin |
| typeMsg | output | 1 | Pin-0 pulse is a message request |
| typeExt | output | 1 | Pin-2 pulse is an external-controller request |
| ackDriveEn | output | 1 | Open-drain pull-low enable for the acknowledge pin |

## Verification
A configuration write that clears one pin's history can land on the same clock edge as another pin's qualification. The bench provokes this with a write that flips only the pin-0 role bit while pins 0 and 1 both fall together. It judges the result by requiring the pin-1 pulse on schedule, with no pin-0 pulse and no message flag. A second overlap occurs when the acknowledge role is on while pin 3 is driven low for several clocks. There the latched acknowledge enable must stay high and `pend[3]` must stay silent.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int PIN_COUNT = 4;
  localparam int CFG_W     = 4;

  // configuration bit positions
  localparam int CFG_ASYNC = 0;
  localparam int CFG_EXT2  = 1;
  localparam int CFG_ACK3  = 2;
  localparam int CFG_MSG0  = 3;

  // pins whose role can change
  localparam int MSG_PIN = 0;
  localparam int EXT_PIN = 2;
  localparam int ACK_PIN = 3;

  typedef struct packed {
    logic [PIN_COUNT-1:0] clrQual;
    logic [PIN_COUNT-1:0] pinEn;
    logic [PIN_COUNT-1:0] tag;
    logic                 asyncSel;
  } qualStrobe_t;

  function automatic int roleBitOf(int pin);
    if (pin == MSG_PIN) return CFG_MSG0;
    if (pin == EXT_PIN) return CFG_EXT2;
    if (pin == ACK_PIN) return CFG_ACK3;
    return -1;
  endfunction
endpackage

// File: rtl/pin_irq_qual.sv
module pin_irq_qual #(
  parameter int SYNC_NEED  = 1,
  parameter int ASYNC_NEED = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic en,
  input  logic asyncSel,
  input  logic activeLvl,
  input  logic tagIn,
  output logic fire,
  output logic tagOut
);
  localparam int MAX_NEED = (ASYNC_NEED > SYNC_NEED) ? ASYNC_NEED : SYNC_NEED;
  localparam int CNT_W    = $clog2(MAX_NEED + 1);
  localparam logic [CNT_W-1:0] SYNC_N  = CNT_W'(SYNC_NEED);
  localparam logic [CNT_W-1:0] ASYNC_N = CNT_W'(ASYNC_NEED);

  logic [CNT_W-1:0] idleCnt;
  logic [CNT_W-1:0] activeCnt;
  logic [CNT_W-1:0] needSel;
  logic             armed;

  assign needSel = asyncSel ? ASYNC_N : SYNC_N;
  assign armed   = (idleCnt >= needSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt   <= '0;
      activeCnt <= '0;
      fire      <= 1'b0;
      tagOut    <= 1'b0;
    end else begin
      fire   <= 1'b0;
      tagOut <= 1'b0;
      if (clr || !en) begin
        idleCnt   <= '0;
        activeCnt <= '0;
      end else if (!activeLvl) begin
        activeCnt <= '0;
        if (!armed) idleCnt <= idleCnt + CNT_W'(1);
      end else if (armed) begin
        if ((activeCnt + CNT_W'(1)) >= needSel) begin
          fire      <= 1'b1;
          tagOut    <= tagIn;
          idleCnt   <= '0;
          activeCnt <= '0;
        end else begin
          activeCnt <= activeCnt + CNT_W'(1);
        end
      end else begin
        idleCnt   <= '0;
        activeCnt <= '0;
      end
    end
  end
endmodule

// File: rtl/pin_irq_datapath.sv
module pin_irq_datapath
  import pin_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SYNC_NEED   = 1,
  parameter int ASYNC_NEED  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  qualStrobe_t          strobe,
  input  logic [PIN_COUNT-1:0] pinN,
  output logic [PIN_COUNT-1:0] pend,
  output logic [PIN_COUNT-1:0] tagOut
);
  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    logic [SYNC_STAGES-1:0] chain;
    logic                   activeLvl;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], pinN[p]};
    end

    assign activeLvl = strobe.asyncSel ? ~chain[SYNC_STAGES-1] : ~chain[0];

    pin_irq_qual #(
      .SYNC_NEED (SYNC_NEED),
      .ASYNC_NEED(ASYNC_NEED)
    ) u_qual (
      .clk      (clk),
      .rstN     (rstN),
      .clr      (strobe.clrQual[p]),
      .en       (strobe.pinEn[p]),
      .asyncSel (strobe.asyncSel),
      .activeLvl(activeLvl),
      .tagIn    (strobe.tag[p]),
      .fire     (pend[p]),
      .tagOut   (tagOut[p])
    );
  end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             ackLoad,
  input  logic             ackAssert,
  output qualStrobe_t      strobe,
  output logic [CFG_W-1:0] cfgQ,
  output logic             ackDriveEn
);
  logic [CFG_W-1:0]     cfgDiff;
  logic [PIN_COUNT-1:0] clrVec;
  logic [PIN_COUNT-1:0] enVec;
  logic [PIN_COUNT-1:0] tagVec;
  logic                 ackLatch;

  assign cfgDiff = cfgWe ? (cfgData ^ cfgQ) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfgQ <= '0;
    else if (cfgWe) cfgQ <= cfgData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ackLatch <= 1'b0;
    else if (ackLoad) ackLatch <= ackAssert;
  end

  assign ackDriveEn = ackLatch & cfgQ[CFG_ACK3];

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_role
    localparam int RB = roleBitOf(p);
    if (RB >= 0) begin : g_roled
      assign clrVec[p] = cfgDiff[CFG_ASYNC] | cfgDiff[RB];
    end else begin : g_plain
      assign clrVec[p] = cfgDiff[CFG_ASYNC];
    end
    if (p == ACK_PIN) begin : g_en_ack
      assign enVec[p] = ~cfgQ[CFG_ACK3];
    end else begin : g_en_on
      assign enVec[p] = 1'b1;
    end
    if (p == MSG_PIN) begin : g_tag_msg
      assign tagVec[p] = cfgQ[CFG_MSG0];
    end else if (p == EXT_PIN) begin : g_tag_ext
      assign tagVec[p] = cfgQ[CFG_EXT2];
    end else begin : g_tag_none
      assign tagVec[p] = 1'b0;
    end
  end

  assign strobe.clrQual  = clrVec;
  assign strobe.pinEn    = enVec;
  assign strobe.tag      = tagVec;
  assign strobe.asyncSel = cfgQ[CFG_ASYNC];
endmodule

// File: rtl/pin_irq_qualifier.sv
module pin_irq_qualifier
  import pin_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SYNC_NEED   = 1,
  parameter int ASYNC_NEED  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [CFG_W-1:0]     cfgData,
  input  logic [PIN_COUNT-1:0] pinN,
  input  logic                 ackLoad,
  input  logic                 ackAssert,
  output logic [PIN_COUNT-1:0] pend,
  output logic                 typeMsg,
  output logic                 typeExt,
  output logic                 ackDriveEn
);
  qualStrobe_t          strobe;
  logic [CFG_W-1:0]     cfgQ;
  logic [PIN_COUNT-1:0] tagOut;

  pin_irq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgData   (cfgData),
    .ackLoad   (ackLoad),
    .ackAssert (ackAssert),
    .strobe    (strobe),
    .cfgQ      (cfgQ),
    .ackDriveEn(ackDriveEn)
  );

  pin_irq_datapath #(
    .SYNC_STAGES(SYNC_STAGES),
    .SYNC_NEED  (SYNC_NEED),
    .ASYNC_NEED (ASYNC_NEED)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .pinN  (pinN),
    .pend  (pend),
    .tagOut(tagOut)
  );

  assign typeMsg = tagOut[MSG_PIN];
  assign typeExt = tagOut[EXT_PIN];
endmodule

// File: rtl/pin_irq_checker.sv
module pin_irq_checker
  import pin_irq_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 cfgWe,
  input logic                 ackLoad,
  input logic [PIN_COUNT-1:0] pend,
  input logic                 typeMsg,
  input logic                 typeExt,
  input logic                 ackDriveEn,
  input logic                 ackMode
);
  // R4: a pulse is never followed by another on the same pin
  p_pulse_once_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pend != '0) |=> ((pend & $past(pend)) == '0));

  // R5
  p_msg_tag_r5: assert property (@(posedge clk) disable iff (!rstN)
    typeMsg |-> pend[MSG_PIN]);

  // R6
  p_ext_tag_r6: assert property (@(posedge clk) disable iff (!rstN)
    typeExt |-> pend[EXT_PIN]);

  // R7: pin 3 silent while it has been an output
  p_ack_pin_silent_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ackMode && $past(ackMode)) |-> !pend[ACK_PIN]);

  // R8
  p_ack_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!ackLoad && !cfgWe) |=> $stable(ackDriveEn));

  // R9
  always @(posedge clk) begin
    if (!rstN) begin
      p_reset_quiet_r9: assert (pend == '0 && !typeMsg && !typeExt && !ackDriveEn);
    end
  end
endmodule

bind pin_irq_qualifier pin_irq_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cfgWe     (cfgWe),
  .ackLoad   (ackLoad),
  .pend      (pend),
  .typeMsg   (typeMsg),
  .typeExt   (typeExt),
  .ackDriveEn(ackDriveEn),
  .ackMode   (cfgQ[pin_irq_pkg::CFG_ACK3])
);

// File: tb/pin_irq_qualifier_tb.sv
`timescale 1ns/1ps
module pin_irq_qualifier_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0;
  logic [3:0] cfgData = 4'h0;
  logic [3:0] pinN = 4'hF;
  logic       ackLoad = 1'b0;
  logic       ackAssert = 1'b0;
  logic [3:0] pend;
  logic       typeMsg;
  logic       typeExt;
  logic       ackDriveEn;

  int applied = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pin_irq_qualifier u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgData(cfgData), .pinN(pinN),
    .ackLoad(ackLoad), .ackAssert(ackAssert), .pend(pend),
    .typeMsg(typeMsg), .typeExt(typeExt), .ackDriveEn(ackDriveEn)
  );

  typedef struct packed {
    logic       we;
    logic [3:0] cfg;
    logic [3:0] pins;
    logic       ld;
    logic       val;
    logic [3:0] ePend;
    logic       eMsg;
    logic       eExt;
    logic       eAck;
  } vec_t;

  localparam int NV = 51;
  localparam vec_t VECS [NV] = '{
    // sync mode: R1, R4
    '{1'b0,4'h0,4'hE,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h0,4'hE,1'b0,1'b0,4'h1,1'b0,1'b0,1'b0},
    '{1'b0,4'h0,4'hE,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h0,4'hF,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h0,4'hE,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h0,4'hE,1'b0,1'b0,4'h1,1'b0,1'b0,1'b0},
    '{1'b0,4'h0,4'hF,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    // roles: R5, R6
    '{1'b1,4'hA,4'hF,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'hA,4'hF,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'hA,4'hA,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'hA,4'hA,1'b0,1'b0,4'h5,1'b1,1'b1,1'b0},
    '{1'b0,4'hA,4'hF,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'hA,4'hF,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    // same-edge clear of pin 0 while pin 1 qualifies: R10
    '{1'b1,4'h2,4'hC,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h2,4'hC,1'b0,1'b0,4'h2,1'b0,1'b0,1'b0},
    '{1'b0,4'h2,4'hC,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h2,4'hF,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    // acknowledge role: R7, R8
    '{1'b1,4'h6,4'hF,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h6,4'hF,1'b1,1'b1,4'h0,1'b0,1'b0,1'b1},
    '{1'b0,4'h6,4'h7,1'b0,1'b0,4'h0,1'b0,1'b0,1'b1},
    '{1'b0,4'h6,4'h7,1'b0,1'b0,4'h0,1'b0,1'b0,1'b1},
    '{1'b0,4'h6,4'h7,1'b0,1'b0,4'h0,1'b0,1'b0,1'b1},
    '{1'b0,4'h6,4'hF,1'b1,1'b0,4'h0,1'b0,1'b0,1'b0},
    // async mode: R2
    '{1'b1,4'h1,4'hF,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hF,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hF,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hD,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hD,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hD,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hD,1'b0,1'b0,4'h2,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hD,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    // async glitches: R3
    '{1'b0,4'h1,4'hF,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hF,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hF,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hF,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hD,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hF,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hF,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hF,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hF,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hF,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hD,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hD,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hD,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hD,1'b0,1'b0,4'h2,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hF,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hD,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hD,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hD,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hD,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0},
    '{1'b0,4'h1,4'hD,1'b0,1'b0,4'h0,1'b0,1'b0,1'b0}
  };

  function automatic string reqOf(int j);
    if (j < 7)  return "R1/R4";
    if (j < 13) return "R5/R6";
    if (j < 17) return "R10";
    if (j < 23) return "R7/R8";
    if (j < 31) return "R2";
    return "R3";
  endfunction

  task automatic checkOut(string req, logic [3:0] ePend, logic eMsg, logic eExt, logic eAck);
    applied++;
    if (pend !== ePend || typeMsg !== eMsg || typeExt !== eExt || ackDriveEn !== eAck) begin
      bad++;
      $display("FAIL %s: got pend=%b msg=%b ext=%b ack=%b, expected pend=%b msg=%b ext=%b ack=%b",
               req, pend, typeMsg, typeExt, ackDriveEn, ePend, eMsg, eExt, eAck);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    // R9: outputs quiet during reset
    idle(3);
    checkOut("R9", 4'h0, 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;
    idle(4);
    checkOut("R9", 4'h0, 1'b0, 1'b0, 1'b0);

    for (int j = 0; j < NV; j++) begin
      cfgWe     = VECS[j].we;
      cfgData   = VECS[j].cfg;
      pinN      = VECS[j].pins;
      ackLoad   = VECS[j].ld;
      ackAssert = VECS[j].val;
      @(negedge clk);
      checkOut(reqOf(j), VECS[j].ePend, VECS[j].eMsg, VECS[j].eExt, VECS[j].eAck);
    end
    cfgWe = 1'b0; ackLoad = 1'b0; pinN = 4'hF;

    // R9: reset while the acknowledge is being driven
    cfgWe = 1'b1; cfgData = 4'h4;
    @(negedge clk);
    cfgWe = 1'b0; ackLoad = 1'b1; ackAssert = 1'b1;
    @(negedge clk);
    ackLoad = 1'b0;
    checkOut("R7", 4'h0, 1'b0, 1'b0, 1'b1);
    rstN = 1'b0;
    #1;
    checkOut("R9", 4'h0, 1'b0, 1'b0, 1'b0);
    idle(2);
    rstN = 1'b1;
    idle(3);
    checkOut("R9", 4'h0, 1'b0, 1'b0, 1'b0);

    // R1: configuration back at zero, so sync timing and pin 3 is an input
    pinN = 4'h7;
    @(negedge clk);
    checkOut("R1", 4'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    checkOut("R1", 4'h8, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    checkOut("R4", 4'h0, 1'b0, 1'b0, 1'b0);
    pinN = 4'hF;
    idle(2);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule